// File: doc/BRIEF.md
# Strobed Parallel Input Port

This block is an 8-bit bidirectional port mapped into a small register space. Each pin has its own direction bit. A pin set as an output drives the value held in the port data register. A pin set as an input is read straight from its pad. An external strobe line captures a snapshot of the port. When the selected edge appears on that line, the current port view is copied into a latch register and a capture flag is set. The flag and an enable bit together raise a level interrupt request.

Software reaches the block through a simple register bus. The bus has a read strobe, a write strobe, a 3-bit byte offset and 8-bit write data. Read data is returned combinationally in the same cycle. The flag is cleared by a fixed pair of reads. First the control register is read while the flag is set. Later the latch register is read. Because of this order, an interrupt handler that follows it cannot drop a capture without having looked at it. The strobe is passed through a two-flop synchronizer before edge detection, so it may be fully asynchronous to the bus clock.

Top module: `strobe_port`

## Requirements
- R1: After reset the control register reads 0x03, the direction register reads 0x00, pin_oe is 0x00, irq is 0 and strb_out is 0.
- R2: A write to offset 0x02 stores bits 6..0 of the control register. Bit 7 (capture flag) is read-only, so writing 0xFF with the flag clear reads back 0x7F. Bit 6 is the interrupt enable, bit 4 the handshake select, bit 1 the edge select and bit 0 the strobe-output invert.
- R3: A write to offset 0x07 sets the direction register, and pin_oe equals it (1 = output). A write to offset 0x03 sets the output register, and pin_out equals it.
- R4: A read of offset 0x03 returns, for each bit, the output register bit if that pin is an output and the pad bit otherwise.
- R5: With handshake select 0, the strobe is synchronized by two flops. The active edge is falling when bit 1 = 0 and rising when bit 1 = 1. On that edge the live port view (as in R4) is stored in the latch register (read at offset 0x05) and the capture flag is set. The opposite edge has no effect.
- R6: While handshake select (bit 4) is 1, strobe edges neither set the flag nor change the latch.
- R7: irq is 1 exactly when the capture flag and the interrupt enable (bit 6) are both 1.
- R8: The flag clears when a read of offset 0x05 follows an earlier read of offset 0x02 made while the flag was 1. A read of offset 0x05 without that prior control read leaves the flag set.
- R9: If an active edge is detected in the same cycle as the clearing latch read, the flag stays set and the latch takes the new port view.
- R10: strb_out is the idle strobe-output level, the inverse of control bit 0 (bit 0 = 0 gives 1, bit 0 = 1 gives 0).
- R11: Writes to offset 0x05 are ignored. Reads of unmapped offsets, and bus_rdata when bus_rd is 0, return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle |
| pad_in | input | 8 | Pad input values |
| strobe_in | input | 1 | External capture strobe, asynchronous |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Per-pin output enable |
| strb_out | output | 1 | Strobe output idle level |
| irq | output | 1 | Level interrupt request |

## Verification
Some rules are checked by the built-in assertions on every clock. The flag can rise only after a detected active edge, and never while handshake select is set. The latch changes only on a capture. The flag falls only on an armed latch read. A capture that coincides with the clearing read keeps the flag set. Other behaviour can only be shown by the bench's scenarios. These are the exact byte captured from a mix of driven and input pins, the read-back masking of the control register, the ignored latch write and the unarmed latch read, and the three-cycle delay from a strobe change to the flag. For these, a behavioural model is compared against the outputs in every cycle.

// File: rtl/strobe_port.sv
module strobe_port #(
  parameter int W      = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  input  logic              strobe_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic              strb_out,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFF_CTL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFF_DAT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFF_LAT = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] OFF_DIR = ADDR_W'(7);
  localparam logic [6:0]        CTL_RST = 7'b000_0011;

  logic [6:0]   ctl_q;
  logic         flag;
  logic         armed;
  logic [W-1:0] dir_q, out_q, latch_q;
  logic [2:0]   sync_q;

  wire [W-1:0] live    = (dir_q & out_q) | (~dir_q & pad_in);
  wire         rise    = sync_q[1] & ~sync_q[2];
  wire         fall    = ~sync_q[1] & sync_q[2];
  wire         edge_hit = ~ctl_q[4] & (ctl_q[1] ? rise : fall);
  wire         rd_ctl  = bus_rd && bus_addr == OFF_CTL;
  wire         clr_rd  = bus_rd && bus_addr == OFF_LAT && armed && flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], strobe_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
      dir_q <= '0;
      out_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFF_CTL: ctl_q <= bus_wdata[6:0];
        OFF_DAT: out_q <= bus_wdata;
        OFF_DIR: dir_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      armed   <= 1'b0;
      latch_q <= '0;
    end else if (edge_hit) begin
      flag    <= 1'b1;
      armed   <= 1'b0;
      latch_q <= live;
    end else if (clr_rd) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (rd_ctl && flag) begin
      armed <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFF_CTL: bus_rdata = {flag, ctl_q};
        OFF_DAT: bus_rdata = live;
        OFF_LAT: bus_rdata = latch_q;
        OFF_DIR: bus_rdata = dir_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pin_out  = out_q;
  assign pin_oe   = dir_q;
  assign strb_out = ~ctl_q[0];
  assign irq      = flag & ctl_q[6];

  a_r5_flag_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(edge_hit));
  a_r5_latch_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(edge_hit) |-> $stable(latch_q));
  a_r6_no_capture_in_hs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> !$past(ctl_q[4]));
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctl_q[6]);
  a_r8_clear_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(bus_rd && bus_addr == OFF_LAT && armed));
  a_r9_coincident_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && clr_rd) |=> flag);
endmodule

// File: tb/strobe_port_bench.sv
`timescale 1ns/1ps
module strobe_port_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_rd = 0, bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = 0;
  logic       strobe_in = 0;
  logic [7:0] pin_out, pin_oe;
  logic       strb_out, irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  strobe_port u_strobe_port (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .strobe_in(strobe_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .strb_out(strb_out), .irq(irq));

  // behavioural reference
  logic [7:0] m_ctl = 8'h03, m_dir = 0, m_out = 0, m_lat = 0;
  bit m_flag = 0, m_arm = 0;
  bit [2:0] m_sync = 0;

  function automatic [7:0] m_live();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = m_dir[i] ? m_out[i] : pad_in[i];
    return v;
  endfunction

  function automatic [7:0] m_read();
    if (!bus_rd) return 8'h00;
    case (bus_addr)
      3'd2: return {m_flag, m_ctl[6:0]};
      3'd3: return m_live();
      3'd5: return m_lat;
      3'd7: return m_dir;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 8'h03; m_dir = 0; m_out = 0; m_lat = 0;
      m_flag = 0; m_arm = 0; m_sync = 0;
    end else begin
      bit active, prev, cur;
      logic [7:0] lv;
      prev = m_sync[2]; cur = m_sync[1];
      active = !m_ctl[4] && (m_ctl[1] ? (cur && !prev) : (!cur && prev));
      lv = m_live();
      if (active) begin
        m_flag = 1; m_arm = 0; m_lat = lv;
      end else if (bus_rd && bus_addr == 5 && m_arm && m_flag) begin
        m_flag = 0; m_arm = 0;
      end else if (bus_rd && bus_addr == 2 && m_flag) m_arm = 1;
      if (bus_wr) begin
        if (bus_addr == 2) m_ctl = {1'b0, bus_wdata[6:0]};
        else if (bus_addr == 3) m_out = bus_wdata;
        else if (bus_addr == 7) m_dir = bus_wdata;
      end
      m_sync = {m_sync[1:0], strobe_in};
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk); #3;
    if (rst_n) begin
      check("R4", "rdata vs model", bus_rdata, m_read());
      check("R3", "pin_out vs model", pin_out, m_out);
      check("R3", "pin_oe vs model", pin_oe, m_dir);
      check("R7", "irq vs model", irq, m_flag & m_ctl[6]);
      check("R10", "strb_out vs model", strb_out, !m_ctl[0]);
    end
  end

  task automatic wr(input [2:0] a, input [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input [2:0] a, output [7:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = a; #2 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic strobe(input bit lvl);
    @(negedge clk); strobe_in = lvl;
    repeat (4) @(negedge clk);
    #2;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    check("R1", "pin_oe reset", pin_oe, 8'h00);
    check("R1", "irq reset", irq, 0);
    check("R1", "strb_out reset", strb_out, 0);
    rd(3'd2, v); check("R1", "ctl reset", v, 8'h03);
    rd(3'd7, v); check("R1", "dir reset", v, 8'h00);

    wr(3'd7, 8'hF0); wr(3'd3, 8'h93); pad_in = 8'h5A;
    #2;
    check("R3", "pin_oe", pin_oe, 8'hF0);
    check("R3", "pin_out", pin_out, 8'h93);
    rd(3'd3, v); check("R4", "live mixed read", v, 8'h9A);

    wr(3'd2, 8'hFF); rd(3'd2, v); check("R2", "ctl masked", v, 8'h7F);
    strobe(1); rd(3'd2, v); check("R6", "no capture in handshake", v, 8'h7F);
    strobe(0);
    wr(3'd2, 8'h42); #2 check("R10", "strb_out inv0", strb_out, 1);
    wr(3'd2, 8'h43); #2 check("R10", "strb_out inv1", strb_out, 0);

    pad_in = 8'hC5; strobe(1);
    check("R7", "irq on capture", irq, 1);
    rd(3'd5, v); check("R5", "rising capture", v, 8'h95);
    #2 check("R8", "unarmed read keeps flag", irq, 1);
    rd(3'd2, v); check("R8", "ctl shows flag", v, 8'hC3);
    rd(3'd5, v); #2 check("R8", "armed read clears", irq, 0);
    rd(3'd2, v); check("R8", "flag clear", v, 8'h43);

    wr(3'd2, 8'h41); pad_in = 8'h3C; strobe(0);
    check("R5", "falling edge flag", irq, 1);
    rd(3'd2, v); rd(3'd5, v); check("R5", "falling capture", v, 8'h9C);
    #2 check("R8", "cleared again", irq, 0);
    strobe(1); check("R5", "rising ignored in fall mode", irq, 0);

    pad_in = 8'h11; strobe(0);
    strobe(1);
    rd(3'd2, v);
    pad_in = 8'h22;
    @(negedge clk); strobe_in = 0;
    @(negedge clk);
    @(negedge clk); bus_rd = 1; bus_addr = 3'd5; #2 v = bus_rdata;
    check("R9", "old latch during read", v, 8'h91);
    @(negedge clk); bus_rd = 0; #2;
    check("R9", "flag kept on coincident edge", irq, 1);
    rd(3'd5, v); check("R9", "latch took new data", v, 8'h92);

    wr(3'd5, 8'hAA); rd(3'd5, v); check("R11", "latch write ignored", v, 8'h92);
    rd(3'd0, v); check("R11", "unmapped 0", v, 8'h00);
    rd(3'd6, v); check("R11", "unmapped 6", v, 8'h00);
    #2 check("R11", "idle rdata", bus_rdata, 8'h00);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule